// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the slave-side serial interface of a page-organised flash memory. The memory keeps one SRAM data buffer the size of a page, 264 bytes by default. The host talks to it over a four-wire serial link: clock, active-low select, data in and data out. The block decodes the 8-bit opcode and collects the 24 address bits that follow it. It then skips the don't-care bits that the opcode calls for, and either streams bytes into the buffer or streams bytes out. The bytes it sends come from the buffer, from one page of the main array, or from a live status byte.

Commands that start an internal operation (transfer, compare, program, erase, rewrite) are not carried out here. When select rises, the block hands the opcode, page number and byte offset to a separate sequencer as a one-cycle command strobe. The main array is seen as a combinational read port addressed by {page, offset}. The sequencer reaches the buffer through its own read/write port. The data-out pin is modelled as a data bit plus an enable. Everything runs on one system clock. SCK, select and SI pass through two-stage synchronisers, so the system clock must run at least four times the serial clock rate.

Top module: `spi_flash_front`

## Requirements
- R1: Each falling edge of select samples the idle clock level into `idleHighMode` (1 = clock high, mode 3; 0 = clock low, mode 0). The value holds while select stays low, and reset sets it to 1.
- R2: `spiSoEn` is 0 after reset and whenever select has been high for a few system clocks. It goes to 1 when the first output bit of a read is driven. Output bits change on falling SCK, and input bits are sampled on rising SCK, MSB first.
- R3: Opcode 57h (status) streams the status byte on the clocks right after the opcode and repeats it while select stays low. The byte is {bit7 = not busy, bit6 = `cmpMismatch`, bits5:3 = density code (default 001), bits2:0 = 000}, read live. Busy does not block this opcode.
- R4: Opcode 84h (buffer write) takes 24 address bits, of which bits 8:0 give the buffer start and the upper 15 are ignored. Each complete data byte after them is written at the pointer, which then steps and wraps from 263 to 0. A start offset of 264 or more is reduced by 264.
- R5: Opcode 54h (buffer read) takes 24 address bits (bits 8:0 = start) and then 8 don't-care bits. It then streams buffer bytes from the start, wrapping from 263 to 0.
- R6: Opcode 52h (page read) takes 24 address bits, with bits 17:9 = page and bits 8:0 = offset, and then 32 don't-care bits. It then streams array bytes of that page from the offset, wrapping to offset 0 of the same page.
- R7: Opcodes 53h, 60h, 83h, 88h, 81h, 50h and 58h produce a one-cycle `cmdValid` when select rises after at least 32 bits. The strobe carries `cmdOp`, with `cmdPage` = address bits 17:9 and `cmdOffset` = address bits 8:0. With fewer bits, no strobe is produced.
- R8: Opcode 82h writes its data bytes into the buffer as R4 describes, and then issues a command strobe with op 82h on the rise of select.
- R9: An unknown opcode is ignored until select rises: no output enable, no buffer write and no command strobe.
- R10: While `seqBusy` is high at the eighth bit, every opcode except 57h is ignored in the same way as R9.
- R11: The sequencer port reads the buffer combinationally at `seqBufAddr` and writes `seqBufWdata` there when `seqBufWe` is high.
- R12: During a page read, `arrAddr` equals {page, current offset}, and the bytes shifted out are `arrData` at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rstN | input | 1 | active-low asynchronous reset |
| spiSck | input | 1 | serial clock, asynchronous |
| spiCsN | input | 1 | active-low select, asynchronous |
| spiSi | input | 1 | serial data in |
| spiSo | output | 1 | serial data out bit |
| spiSoEn | output | 1 | data-out drive enable |
| idleHighMode | output | 1 | clock level seen at the last select fall |
| seqBusy | input | 1 | sequencer is running an operation |
| cmpMismatch | input | 1 | result of the last compare, 1 = differs |
| cmdValid | output | 1 | one-cycle command strobe |
| cmdOp | output | 8 | opcode of the issued command |
| cmdPage | output | 9 | page number of the issued command |
| cmdOffset | output | 9 | byte offset of the issued command |
| arrAddr | output | 18 | main array read address {page, offset} |
| arrData | input | 8 | main array read data |
| seqBufWe | input | 1 | sequencer buffer write enable |
| seqBufAddr | input | 9 | sequencer buffer address |
| seqBufWdata | input | 8 | sequencer buffer write data |
| seqBufRdata | output | 8 | sequencer buffer read data |

## Verification
The bench builds the block with its default parameters: a 264-byte page, 9-bit page and offset fields, and density code 001. A page size that is not a power of two puts the 263-to-0 wrap and the fold of offsets at 264 and above within reach of short transfers. A serial clock of twelve system clocks per bit keeps the synchroniser delay inside each half-period. Both idle clock levels are exercised, and so are reads that start one or two bytes before the wrap point.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

  localparam logic [7:0] OP_PAGE_RD    = 8'h52;
  localparam logic [7:0] OP_BUF_RD     = 8'h54;
  localparam logic [7:0] OP_STATUS     = 8'h57;
  localparam logic [7:0] OP_BUF_WR     = 8'h84;
  localparam logic [7:0] OP_PROG_THRU  = 8'h82;
  localparam logic [7:0] OP_XFER       = 8'h53;
  localparam logic [7:0] OP_CMP        = 8'h60;
  localparam logic [7:0] OP_PROG_ERASE = 8'h83;
  localparam logic [7:0] OP_PROG_PLAIN = 8'h88;
  localparam logic [7:0] OP_PAGE_ERASE = 8'h81;
  localparam logic [7:0] OP_BLK_ERASE  = 8'h50;
  localparam logic [7:0] OP_REWRITE    = 8'h58;

  typedef enum logic [1:0] {SRC_BUF, SRC_ARRAY, SRC_STATUS} srcSel_t;

  typedef enum logic [2:0] {
    K_NONE, K_DROP, K_STATUS, K_BUFRD, K_PAGERD, K_BUFWR, K_PROGWR, K_CMD
  } kind_t;

  typedef struct packed {
    logic    shiftIn;
    logic    latchAddr;
    logic    loadPtr;
    logic    wrByte;
    logic    outStep;
    srcSel_t src;
  } strobe_t;

endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
  parameter int N = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] asyncIn,
  output logic [N-1:0] syncOut
);
  for (genvar g = 0; g < N; g++) begin : gStage
    logic meta;
    logic stable;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        meta   <= RST_VAL[g];
        stable <= RST_VAL[g];
      end else begin
        meta   <= asyncIn[g];
        stable <= meta;
      end
    end
    assign syncOut[g] = stable;
  end
endmodule

// File: rtl/sfe_ctrl.sv
module sfe_ctrl import sfe_pkg::*; #(
  parameter int CNT_W = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csS,
  input  logic       csFall,
  input  logic       csRise,
  input  logic       sckS,
  input  logic       sckRise,
  input  logic       sckFall,
  input  logic       siS,
  input  logic [6:0] inTail,
  input  logic       seqBusy,
  output strobe_t    stb,
  output logic       cmdValid,
  output logic [7:0] cmdOp,
  output logic       modeHigh
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] OP_LAST = CNT_W'(7);
  localparam logic [CNT_W-1:0] AD_LAST = CNT_W'(31);
  localparam logic [CNT_W-1:0] AD_DONE = CNT_W'(32);

  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] hdrLast;
  kind_t            kind;
  kind_t            newKind;
  logic [7:0]       opReg;
  logic [2:0]       dataCnt;
  logic             dataPhase;
  logic             outActive;

  wire [7:0] newOp    = {inTail, siS};
  wire       liveRise = sckRise & ~csS;
  wire       isRead   = (kind == K_BUFRD) || (kind == K_PAGERD);
  wire       isWrite  = (kind == K_BUFWR) || (kind == K_PROGWR);
  wire       hdrDone  = liveRise && (isRead || isWrite) && (bitCnt == hdrLast);
  wire       issuable = (kind == K_CMD) || (kind == K_PROGWR);

  always_comb begin
    newKind = K_DROP;
    if (newOp == OP_STATUS) begin
      newKind = K_STATUS;
    end else if (!seqBusy) begin
      case (newOp)
        OP_PAGE_RD:   newKind = K_PAGERD;
        OP_BUF_RD:    newKind = K_BUFRD;
        OP_BUF_WR:    newKind = K_BUFWR;
        OP_PROG_THRU: newKind = K_PROGWR;
        OP_XFER, OP_CMP, OP_PROG_ERASE, OP_PROG_PLAIN,
        OP_PAGE_ERASE, OP_BLK_ERASE, OP_REWRITE: newKind = K_CMD;
        default:      newKind = K_DROP;
      endcase
    end
  end

  always_comb begin
    case (kind)
      K_PAGERD: hdrLast = CNT_W'(63);
      K_BUFRD:  hdrLast = CNT_W'(39);
      default:  hdrLast = AD_LAST;
    endcase
  end

  always_comb begin
    stb.shiftIn   = liveRise;
    stb.latchAddr = liveRise && (bitCnt == AD_LAST);
    stb.loadPtr   = hdrDone;
    stb.wrByte    = liveRise && dataPhase && (dataCnt == 3'd7);
    stb.outStep   = sckFall && !csS && outActive;
    case (kind)
      K_PAGERD: stb.src = SRC_ARRAY;
      K_STATUS: stb.src = SRC_STATUS;
      default:  stb.src = SRC_BUF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      kind      <= K_NONE;
      opReg     <= '0;
      dataCnt   <= '0;
      dataPhase <= 1'b0;
      outActive <= 1'b0;
      cmdValid  <= 1'b0;
      cmdOp     <= '0;
      modeHigh  <= 1'b1;
    end else begin
      cmdValid <= 1'b0;
      if (csFall) modeHigh <= sckS;
      if (csRise && issuable && (bitCnt >= AD_DONE)) begin
        cmdValid <= 1'b1;
        cmdOp    <= opReg;
      end
      if (csS) begin
        bitCnt    <= '0;
        kind      <= K_NONE;
        dataCnt   <= '0;
        dataPhase <= 1'b0;
        outActive <= 1'b0;
      end else if (liveRise) begin
        if (bitCnt != CNT_MAX) bitCnt <= bitCnt + 1'b1;
        if (bitCnt == OP_LAST) begin
          opReg <= newOp;
          kind  <= newKind;
          if (newKind == K_STATUS) outActive <= 1'b1;
        end
        if (hdrDone) begin
          if (isRead) outActive <= 1'b1;
          else        dataPhase <= 1'b1;
        end
        if (dataPhase) dataCnt <= dataCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sfe_dp.sv
module sfe_dp import sfe_pkg::*; #(
  parameter int PAGE_BYTES = 264,
  parameter int PG_W = 9,
  parameter int OF_W = 9,
  parameter logic [2:0] DENSITY = 3'b001
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic               siS,
  input  logic               csS,
  input  logic               seqBusy,
  input  logic               cmpMismatch,
  output logic [6:0]         inTail,
  output logic [PG_W-1:0]    pageAddr,
  output logic [OF_W-1:0]    byteAddr,
  output logic [PG_W+OF_W-1:0] arrAddr,
  input  logic [7:0]         arrData,
  input  logic               seqBufWe,
  input  logic [OF_W-1:0]    seqBufAddr,
  input  logic [7:0]         seqBufWdata,
  output logic [7:0]         seqBufRdata,
  output logic               misoBit,
  output logic               misoEn
);
  localparam int AW = PG_W + OF_W;
  localparam logic [OF_W-1:0] SIZE = OF_W'(PAGE_BYTES);
  localparam logic [OF_W-1:0] LAST = OF_W'(PAGE_BYTES - 1);

  logic [AW-2:0]   shiftReg;
  logic [AW-1:0]   addrReg;
  logic [OF_W-1:0] ptr;
  logic [OF_W-1:0] rawOfs;
  logic [OF_W-1:0] ptrLoad;
  logic [OF_W-1:0] ptrInc;
  logic [2:0]      idx;
  logic [7:0]      byteNow;
  logic [7:0]      bufMem [PAGE_BYTES];

  wire [AW-1:0] addrNext = {shiftReg, siS};
  wire [7:0]    dataByte = {shiftReg[6:0], siS};
  wire          seqOk    = seqBufAddr < SIZE;

  assign inTail   = shiftReg[6:0];
  assign pageAddr = addrReg[OF_W +: PG_W];
  assign byteAddr = addrReg[OF_W-1:0];
  assign arrAddr  = {addrReg[OF_W +: PG_W], ptr};
  assign seqBufRdata = seqOk ? bufMem[seqBufAddr] : 8'h00;

  always_comb begin
    rawOfs  = stb.latchAddr ? addrNext[OF_W-1:0] : addrReg[OF_W-1:0];
    ptrLoad = (rawOfs >= SIZE) ? rawOfs - SIZE : rawOfs;
    ptrInc  = (ptr == LAST) ? '0 : ptr + 1'b1;
    case (stb.src)
      SRC_ARRAY:  byteNow = arrData;
      SRC_STATUS: byteNow = {~seqBusy, cmpMismatch, DENSITY, 3'b000};
      default:    byteNow = bufMem[ptr];
    endcase
  end

  always_ff @(posedge clk) begin
    if (stb.wrByte)             bufMem[ptr] <= dataByte;
    else if (seqBufWe && seqOk) bufMem[seqBufAddr] <= seqBufWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      addrReg  <= '0;
      ptr      <= '0;
      idx      <= '0;
      misoBit  <= 1'b0;
      misoEn   <= 1'b0;
    end else begin
      if (stb.shiftIn)   shiftReg <= addrNext[AW-2:0];
      if (stb.latchAddr) addrReg  <= addrNext;
      if (stb.loadPtr)
        ptr <= ptrLoad;
      else if (stb.wrByte || (stb.outStep && idx == 3'd7 && stb.src != SRC_STATUS))
        ptr <= ptrInc;
      if (csS) begin
        misoEn <= 1'b0;
        idx    <= '0;
      end else if (stb.outStep) begin
        misoBit <= byteNow[~idx];
        misoEn  <= 1'b1;
        idx     <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_flash_front.sv
module spi_flash_front import sfe_pkg::*; #(
  parameter int PAGE_BYTES = 264,
  parameter int PG_W = 9,
  parameter int OF_W = 9,
  parameter logic [2:0] DENSITY = 3'b001,
  parameter int CNT_W = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 spiSck,
  input  logic                 spiCsN,
  input  logic                 spiSi,
  output logic                 spiSo,
  output logic                 spiSoEn,
  output logic                 idleHighMode,
  input  logic                 seqBusy,
  input  logic                 cmpMismatch,
  output logic                 cmdValid,
  output logic [7:0]           cmdOp,
  output logic [PG_W-1:0]      cmdPage,
  output logic [OF_W-1:0]      cmdOffset,
  output logic [PG_W+OF_W-1:0] arrAddr,
  input  logic [7:0]           arrData,
  input  logic                 seqBufWe,
  input  logic [OF_W-1:0]      seqBufAddr,
  input  logic [7:0]           seqBufWdata,
  output logic [7:0]           seqBufRdata
);
  logic [2:0] pinsS;
  logic       sckD;
  logic       csD;
  logic [6:0] inTail;
  strobe_t    stb;

  sfe_sync #(.N(3), .RST_VAL(3'b011)) u_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({spiSi, spiCsN, spiSck}),
    .syncOut(pinsS)
  );

  wire sckS = pinsS[0];
  wire csS  = pinsS[1];
  wire siS  = pinsS[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckD <= 1'b1;
      csD  <= 1'b1;
    end else begin
      sckD <= sckS;
      csD  <= csS;
    end
  end

  wire sckRise = sckS & ~sckD;
  wire sckFall = ~sckS & sckD;
  wire csFall  = ~csS & csD;
  wire csRise  = csS & ~csD;

  sfe_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .csS(csS), .csFall(csFall), .csRise(csRise),
    .sckS(sckS), .sckRise(sckRise), .sckFall(sckFall), .siS(siS),
    .inTail(inTail), .seqBusy(seqBusy), .stb(stb),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .modeHigh(idleHighMode)
  );

  sfe_dp #(.PAGE_BYTES(PAGE_BYTES), .PG_W(PG_W), .OF_W(OF_W), .DENSITY(DENSITY)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .siS(siS), .csS(csS),
    .seqBusy(seqBusy), .cmpMismatch(cmpMismatch), .inTail(inTail),
    .pageAddr(cmdPage), .byteAddr(cmdOffset), .arrAddr(arrAddr), .arrData(arrData),
    .seqBufWe(seqBufWe), .seqBufAddr(seqBufAddr), .seqBufWdata(seqBufWdata),
    .seqBufRdata(seqBufRdata), .misoBit(spiSo), .misoEn(spiSoEn)
  );
endmodule

// File: rtl/spi_flash_front_chk.sv
module spi_flash_front_chk (
  input logic       clk,
  input logic       rstN,
  input logic       spiCsN,
  input logic       spiSoEn,
  input logic       idleHighMode,
  input logic       cmdValid,
  input logic [7:0] cmdOp
);
  logic [2:0] age;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           age <= '0;
    else if (age != 3'd7) age <= age + 1'b1;
  end

  assert_so_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (age >= 3'd4 && spiCsN && $past(spiCsN) && $past(spiCsN, 2) && $past(spiCsN, 3))
      |-> !spiSoEn);

  assert_quiet_on_issue_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !spiSoEn);

  assert_mode_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (age >= 3'd5 && !spiCsN && !$past(spiCsN) && !$past(spiCsN, 2)
      && !$past(spiCsN, 3) && !$past(spiCsN, 4)) |-> $stable(idleHighMode));

  assert_cmd_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  assert_cmd_legal_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdOp inside {8'h53, 8'h60, 8'h83, 8'h88, 8'h81, 8'h50, 8'h58, 8'h82}));
endmodule

bind spi_flash_front spi_flash_front_chk u_chk (
  .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiSoEn(spiSoEn),
  .idleHighMode(idleHighMode), .cmdValid(cmdValid), .cmdOp(cmdOp)
);

// File: tb/spi_flash_front_bench.sv
module spi_flash_front_bench;
  localparam int HP = 6;
  localparam int NB = 264;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, sck = 1'b1, csN = 1'b1, si = 1'b0;
  logic seqBusy = 1'b0, cmpMis = 1'b0, seqWe = 1'b0;
  logic [8:0] seqAddr = '0;
  logic [7:0] seqWd = '0;
  logic so, soEn, modeHi, cmdValid;
  logic [7:0] cmdOp, arrData, seqRd;
  logic [8:0] cmdPage, cmdOffset;
  logic [17:0] arrAddr;

  function automatic logic [7:0] arrByte(input logic [17:0] a);
    return a[7:0] ^ a[16:9] ^ {a[17], a[8], 6'h1B};
  endfunction
  assign arrData = arrByte(arrAddr);

  spi_flash_front u_spi_flash_front (
    .clk(clk), .rstN(rstN), .spiSck(sck), .spiCsN(csN), .spiSi(si),
    .spiSo(so), .spiSoEn(soEn), .idleHighMode(modeHi),
    .seqBusy(seqBusy), .cmpMismatch(cmpMis),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdPage(cmdPage), .cmdOffset(cmdOffset),
    .arrAddr(arrAddr), .arrData(arrData),
    .seqBufWe(seqWe), .seqBufAddr(seqAddr), .seqBufWdata(seqWd), .seqBufRdata(seqRd)
  );

  logic [7:0] model [NB];
  int nChk = 0, nBad = 0, nCmd = 0;
  logic [7:0] lastOp;
  logic [8:0] lastPage, lastOfs;
  logic curHigh = 1'b1;
  logic done = 1'b0;

  always @(negedge clk) if (cmdValid) begin
    nCmd++;
    lastOp = cmdOp; lastPage = cmdPage; lastOfs = cmdOffset;
  end

  function automatic int wrapOfs(input int o);
    return o % NB;
  endfunction

  function automatic logic [7:0] statusExp(input logic busy, input logic cmp);
    return {~busy, cmp, 3'b001, 3'b000};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic csOpen(input logic high);
    curHigh = high; sck = high;
    repeat (HP) @(negedge clk);
    csN = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic csClose();
    sck = curHigh;
    repeat (HP) @(negedge clk);
    csN = 1'b1;
    repeat (4 * HP) @(negedge clk);
  endtask

  task automatic xbyte(input logic [7:0] d, output logic [7:0] q);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; si = d[i];
      repeat (HP) @(negedge clk);
      q[i] = so;
      sck = 1'b1;
      repeat (HP) @(negedge clk);
    end
  endtask

  task automatic hdr(input logic [7:0] op, input logic [23:0] a, input int dummy);
    logic [7:0] q;
    xbyte(op, q); xbyte(a[23:16], q); xbyte(a[15:8], q); xbyte(a[7:0], q);
    for (int i = 0; i < dummy; i++) xbyte(8'h00, q);
  endtask

  task automatic seqRead(input int a, output logic [7:0] d);
    seqAddr = 9'(a);
    @(negedge clk);
    d = seqRd;
  endtask

  task automatic seqWrite(input int a, input logic [7:0] d);
    seqAddr = 9'(a); seqWd = d; seqWe = 1'b1;
    @(negedge clk);
    seqWe = 1'b0;
  endtask

  task automatic bufWrite(input logic high, input int start, input int len, input logic [7:0] op);
    logic [7:0] q, d;
    csOpen(high);
    hdr(op, {6'h00, 9'h0A3, 9'(start)}, 0);
    for (int i = 0; i < len; i++) begin
      d = 8'($urandom);
      xbyte(d, q);
      if (!seqBusy) model[wrapOfs((start % NB) + i)] = d;
    end
    csClose();
  endtask

  task automatic bufReadCheck(input logic high, input int start, input int len, input string req);
    logic [7:0] q;
    csOpen(high);
    hdr(8'h54, {15'h0, 9'(start)}, 1);
    for (int i = 0; i < len; i++) begin
      xbyte(8'h00, q);
      check(req, q, model[wrapOfs(start + i)]);
    end
    csClose();
  endtask

  initial begin
    logic [7:0] q, r;
    logic [8:0] pg;
    logic [7:0] ops [7];
    void'($urandom(32'd4242));
    ops[0] = 8'h53; ops[1] = 8'h60; ops[2] = 8'h83; ops[3] = 8'h88;
    ops[4] = 8'h81; ops[5] = 8'h50; ops[6] = 8'h58;
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset mode", modeHi, 1);
    check("R2 reset enable", soEn, 0);
    check("R7 reset strobe", cmdValid, 0);

    // R11: preload buffer through the sequencer port
    for (int i = 0; i < NB; i++) begin
      model[i] = 8'($urandom);
      seqWrite(i, model[i]);
    end
    seqRead(0, q);   check("R11 seq read 0", q, model[0]);
    seqRead(263, q); check("R11 seq read 263", q, model[263]);

    // R3 status in mode 0, live compare bit
    seqBusy = 0; cmpMis = 1;
    csOpen(1'b0);
    xbyte(8'h57, q);
    xbyte(8'h00, q); check("R3 status first", q, statusExp(0, 1));
    check("R1 mode0 captured", modeHi, 0);
    check("R2 enable during read", soEn, 1);
    cmpMis = 0;
    xbyte(8'h00, q); check("R3 status repeat fresh", q, statusExp(0, 0));
    csClose();
    check("R2 enable after close", soEn, 0);

    // R3 status allowed while busy, mode 3
    seqBusy = 1;
    csOpen(1'b1);
    xbyte(8'h57, q);
    xbyte(8'h00, q); check("R3 status busy", q, statusExp(1, 0));
    check("R1 mode3 captured", modeHi, 1);
    csClose();
    seqBusy = 0;

    // R4 buffer write wrapping past 263
    bufWrite(1'b1, 260, 8, 8'h84);
    for (int i = 0; i < 8; i++) begin
      seqRead(wrapOfs(260 + i), q);
      check("R4 write wrap", q, model[wrapOfs(260 + i)]);
    end
    // R4 start offset folded
    bufWrite(1'b0, 300, 2, 8'h84);
    seqRead(36, q); check("R4 folded offset", q, model[36]);

    // R5 buffer read wrap
    bufReadCheck(1'b0, 262, 5, "R5 read wrap");

    // R6/R12 page read wrapping inside page
    pg = 9'h1A5;
    csOpen(1'b1);
    hdr(8'h52, {6'h00, pg, 9'd261}, 4);
    for (int i = 0; i < 6; i++) begin
      xbyte(8'h00, q);
      check("R6 R12 page read", q, arrByte({pg, 9'(wrapOfs(261 + i))}));
    end
    csClose();

    // R7 operation commands
    foreach (ops[k]) begin
      logic [8:0] p, o;
      p = 9'($urandom); o = 9'($urandom);
      nCmd = 0;
      csOpen(k[0]);
      hdr(ops[k], {6'h00, p, o}, 0);
      csClose();
      check("R7 strobe count", nCmd, 1);
      check("R7 op", lastOp, ops[k]);
      check("R7 page", lastPage, p);
      check("R7 offset", lastOfs, o);
    end

    // R7 short command: no strobe
    nCmd = 0;
    csOpen(1'b0);
    xbyte(8'h83, q); xbyte(8'h01, q); xbyte(8'h02, q);
    csClose();
    check("R7 short command", nCmd, 0);

    // R8 program through buffer
    nCmd = 0;
    bufWrite(1'b1, 10, 3, 8'h82);
    check("R8 strobe", nCmd, 1);
    check("R8 op", lastOp, 8'h82);
    check("R8 page", lastPage, 9'h0A3);
    for (int i = 0; i < 3; i++) begin
      seqRead(10 + i, q); check("R8 buffer data", q, model[10 + i]);
    end

    // R9 unknown opcode
    nCmd = 0;
    seqRead(5, r);
    csOpen(1'b0);
    hdr(8'h77, {15'h0, 9'd5}, 0);
    xbyte(8'hC3, q); xbyte(8'h3C, q);
    check("R9 no enable", soEn, 0);
    csClose();
    check("R9 no strobe", nCmd, 0);
    seqRead(5, q); check("R9 buffer untouched", q, r);

    // R10 busy blocks
    seqBusy = 1; nCmd = 0;
    csOpen(1'b1);
    hdr(8'h83, 24'h012345, 0);
    csClose();
    check("R10 command ignored", nCmd, 0);
    bufWrite(1'b0, 5, 1, 8'h84);
    seqRead(5, q); check("R10 write ignored", q, r);
    csOpen(1'b1);
    hdr(8'h54, 24'd5, 1);
    xbyte(8'h00, q);
    check("R10 read ignored", soEn, 0);
    csClose();
    seqBusy = 0;

    // random write/read mix (R4, R5)
    for (int it = 0; it < 8; it++) begin
      int st, ln;
      st = int'($urandom_range(0, NB - 1)); ln = int'($urandom_range(1, 10));
      bufWrite(1'($urandom), st, ln, 8'h84);
      st = int'($urandom_range(0, NB - 1)); ln = int'($urandom_range(1, 6));
      bufReadCheck(1'($urandom), st, ln, "R5 random read");
      st = int'($urandom_range(0, NB - 1));
      seqRead(st, q); check("R4 random via seq port", q, model[st]);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end
endmodule